// File: doc/BRIEF.md
# Multi-CPU Interrupt Controller with Mailboxes

This block collects interrupt causes for a cluster of CPUs and presents each CPU with its own request line. It keeps one pending vector that all CPUs share. The low word of that vector carries a few level-sensitive external lines. The next word carries mailbox bits: each CPU owns two of them, which other CPUs raise to signal it. Every CPU has its own enable vector. It sees a masked source view, which is the pending vector ANDed with its own enables. Its request output is the OR of that view.

Software reaches the block through a 32-bit register port with a byte address. The first word is read-only and reports how many interrupt bits the controller implements. The register banks follow from byte 8 and are separated by a fixed spacing. Each bank is two words: word 0 holds the external lines and word 1 holds the mailboxes. Both the pending bank and the enable bank have set-only and clear-only aliases, so that a CPU can change single bits without a read-modify-write. The source and enable banks are repeated once per CPU at a per-CPU stride. Decoding the request lines into a priority is left to the CPU.

Top module: `mcpu_mbox_intc`

## Requirements
- R1: A read at byte offset 0 returns the interrupt bit count parameter NBITS (64 by default). Offset 4 reads zero.
- R2: The bank spacing is SP = 8 × (1 + (NBITS − 1) / 64), which is 8 by default. The shared pending banks are at 8 + k·SP for k = 0, 1, 2: direct, set-only and clear-only. The per-CPU banks of CPU c are at 8 + (3 + j)·SP + c·4·SP for j = 0, 1, 2, 3: source, enable, enable set-only and enable clear-only. Byte +0 of a bank is word 0 and byte +4 is word 1. With the defaults the shared banks are at 8, 16 and 24, and the banks of CPU c are at 32, 40, 48 and 56, each plus 32·c.
- R3: Pending bits 0..NEXT−1 of word 0 show the level of ext_irq one clock after it is sampled. No write to any pending alias changes them.
- R4: Mailbox bit c·2 + m of word 1 belongs to mailbox m of CPU c. A write to the pending set-only alias sets the written-one bits and leaves the others unchanged. A direct write to the pending word 1 loads all mailbox bits.
- R5: A write to the pending clear-only alias on word 1 clears only the written-one mailbox bits.
- R6: A CPU's enable word can be loaded directly. Writes to its set-only alias set only the written-one bits, and writes to its clear-only alias clear only the written-one bits. Enable bits with no implemented interrupt behind them read zero. No other CPU's enables change.
- R7: The source bank of CPU c reads as the pending vector ANDed with the enables of CPU c.
- R8: cpu_irq[c] is the OR of the source bits of CPU c. It follows a register write one clock later and does not change unless there was a write or a change on ext_irq.
- R9: Reset clears all mailbox bits and all enables, so every cpu_irq is low after reset.
- R10: Reads of unmapped offsets and of set-only or clear-only aliases return zero. Writes to offset 0 and to source banks have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_irq | input | NEXT | Level-sensitive external interrupt lines |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | AW | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| cpu_irq | output | NCPU | Request line per CPU |

## Verification
A wrong mailbox or enable bit shows up on the next read of the pending, enable or source word that holds it. It also moves a cpu_irq line one clock after the write that caused it. The bench therefore follows each write with reads of several views: the shared pending word, the enable word of the CPU that was written, the enables of other CPUs, and all request lines. A bit that lands at the wrong lane or on the wrong CPU gives a wrong value within two cycles. A decode error in the bank stride makes a read of a neighbouring bank return data where zero is expected, or the reverse.

// File: rtl/mcpu_mbox_intc.sv
module mcpu_mbox_intc #(
  parameter int NCPU  = 4,
  parameter int NBITS = 64,
  parameter int NEXT  = 4,
  parameter int AW    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEXT-1:0] ext_irq,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic [NCPU-1:0] cpu_irq
);
  localparam int SP     = 8 * (1 + (NBITS - 1) / 64);
  localparam int W      = SP * 8;
  localparam int MBITS  = 2 * NCPU;
  localparam int MB_LSB = 32;
  localparam int CW     = (NCPU > 1) ? $clog2(NCPU) : 1;
  localparam logic [W-1:0] IMPL =
      ((W'(1) << MBITS) - W'(1)) << MB_LSB | ((W'(1) << NEXT) - W'(1));

  logic [MBITS-1:0] mb;
  logic [NEXT-1:0]  ext_q;
  logic [W-1:0]     en [NCPU];
  logic [W-1:0]     raw_vec, wvec, lane;

  logic          sel_hit, sel_info;
  logic [2:0]    sel_kind;
  logic [CW-1:0] sel_cpu;
  int            sel_word;

  assign raw_vec = (W'(mb) << MB_LSB) | W'(ext_q);

  always_comb begin
    int a, rel, bank, c;
    a = int'(reg_addr);
    rel = 0; bank = 0; c = 0;
    sel_hit = 1'b0; sel_info = (a < 4);
    sel_kind = 3'd0; sel_cpu = '0; sel_word = 0;
    if (a >= 8) begin
      rel = a - 8;
      bank = rel / SP;
      sel_word = (rel % SP) / 4;
      if (bank < 3) begin
        sel_hit = 1'b1;
        sel_kind = 3'(bank);
      end else begin
        c = (bank - 3) / 4;
        if (c < NCPU) begin
          sel_hit = 1'b1;
          sel_cpu = CW'(c);
          sel_kind = 3'(3 + (bank - 3) % 4);
        end
      end
    end
  end

  assign wvec = W'(reg_wdata) << (sel_word * 32);
  assign lane = W'(32'hFFFF_FFFF) << (sel_word * 32);

  always_ff @(posedge clk) ext_q <= ext_irq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mb <= '0;
      for (int c = 0; c < NCPU; c++) en[c] <= '0;
    end else if (reg_wr && sel_hit) begin
      case (sel_kind)
        3'd0: mb <= (mb & ~lane[MB_LSB +: MBITS]) | wvec[MB_LSB +: MBITS];
        3'd1: mb <= mb | wvec[MB_LSB +: MBITS];
        3'd2: mb <= mb & ~wvec[MB_LSB +: MBITS];
        3'd4: en[sel_cpu] <= (en[sel_cpu] & ~lane) | (wvec & IMPL);
        3'd5: en[sel_cpu] <= en[sel_cpu] | (wvec & IMPL);
        3'd6: en[sel_cpu] <= en[sel_cpu] & ~wvec;
        default: ;
      endcase
    end
  end

  always_comb begin
    logic [W-1:0] rv;
    rv = '0;
    if (sel_hit) begin
      case (sel_kind)
        3'd0: rv = raw_vec;
        3'd3: rv = raw_vec & en[sel_cpu];
        3'd4: rv = en[sel_cpu];
        default: rv = '0;
      endcase
    end
    rv = rv >> (sel_word * 32);
    reg_rdata = sel_info ? 32'(NBITS) : rv[31:0];
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_irq
    assign cpu_irq[c] = |(raw_vec & en[c]);
  end
endmodule

module mcpu_mbox_intc_chk #(
  parameter int NCPU  = 4,
  parameter int NBITS = 64,
  parameter int NEXT  = 4,
  parameter int AW    = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NEXT-1:0] ext_irq,
  input logic            reg_wr,
  input logic [AW-1:0]   reg_addr,
  input logic [31:0]     reg_wdata,
  input logic [31:0]     reg_rdata,
  input logic [NCPU-1:0] cpu_irq
);
  localparam int SP     = 8 * (1 + (NBITS - 1) / 64);
  localparam int END    = 8 + (3 + 4 * NCPU) * SP;
  localparam int SRC0W1 = 8 + 3 * SP + 4;

  // R1
  info_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(reg_addr) < 4) |-> reg_rdata == 32'(NBITS));

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(reg_addr) >= END) |-> reg_rdata == 32'd0);

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && $stable(ext_irq)) |=> $stable(cpu_irq));

  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_irq & ~$past(cpu_irq)) != '0) |->
      ($past(reg_wr) || $past(ext_irq) != $past(ext_irq, 2)));

  // R7
  src_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(reg_addr) == SRC0W1 && reg_rdata != 32'd0) |-> cpu_irq[0]);

  // R9
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> cpu_irq == '0);

  logic unused_wd;
  assign unused_wd = ^reg_wdata;
endmodule

bind mcpu_mbox_intc mcpu_mbox_intc_chk #(
  .NCPU(NCPU), .NBITS(NBITS), .NEXT(NEXT), .AW(AW)
) u_chk (.*);

// File: tb/test_mcpu_mbox_intc.sv
module test_mcpu_mbox_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ext_irq = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  cpu_irq;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  mcpu_mbox_intc i_mcpu_mbox_intc (
    .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_irq(cpu_irq)
  );

  // fields: req[77:74] op[73:72] addr[71:64] data[63:32] exp[31:0]
  // op 0 = read and compare, 1 = write, 2 = compare cpu_irq
  localparam int NV = 32;
  localparam logic [77:0] VEC [NV] = '{
    {4'd1,  2'd0, 8'd0,   32'd0,    32'd64},  // R1
    {4'd1,  2'd0, 8'd4,   32'd0,    32'd0},   // R1
    {4'd4,  2'd1, 8'd20,  32'd5,    32'd0},   // R4 post cpu0 mb0, cpu1 mb0
    {4'd4,  2'd0, 8'd12,  32'd0,    32'd5},   // R4 R2
    {4'd7,  2'd0, 8'd36,  32'd0,    32'd0},   // R7
    {4'd8,  2'd2, 8'd0,   32'd0,    32'd0},   // R8
    {4'd6,  2'd1, 8'd52,  32'd3,    32'd0},   // R6
    {4'd6,  2'd0, 8'd44,  32'd0,    32'd3},   // R6
    {4'd7,  2'd0, 8'd36,  32'd0,    32'd1},   // R7
    {4'd8,  2'd2, 8'd0,   32'd0,    32'd1},   // R8
    {4'd6,  2'd1, 8'd84,  32'd12,   32'd0},   // R6 cpu1
    {4'd7,  2'd0, 8'd68,  32'd0,    32'd4},   // R7
    {4'd8,  2'd2, 8'd0,   32'd0,    32'd3},   // R8
    {4'd5,  2'd1, 8'd28,  32'd1,    32'd0},   // R5
    {4'd5,  2'd0, 8'd12,  32'd0,    32'd4},   // R5
    {4'd8,  2'd2, 8'd0,   32'd0,    32'd2},   // R8
    {4'd6,  2'd1, 8'd60,  32'd1,    32'd0},   // R6
    {4'd6,  2'd0, 8'd44,  32'd0,    32'd2},   // R6
    {4'd6,  2'd0, 8'd76,  32'd0,    32'd12},  // R6 other cpu unchanged
    {4'd4,  2'd1, 8'd12,  32'd160,  32'd0},   // R4 direct load
    {4'd4,  2'd0, 8'd12,  32'd0,    32'd160}, // R4
    {4'd8,  2'd2, 8'd0,   32'd0,    32'd0},   // R8
    {4'd6,  2'd1, 8'd140, 32'd128,  32'd0},   // R6 cpu3
    {4'd8,  2'd2, 8'd0,   32'd0,    32'd8},   // R8
    {4'd7,  2'd0, 8'd132, 32'd0,    32'd128}, // R7
    {4'd10, 2'd1, 8'd36,  32'd255,  32'd0},   // R10 source write ignored
    {4'd10, 2'd0, 8'd12,  32'd0,    32'd160}, // R10
    {4'd10, 2'd1, 8'd0,   32'd4660, 32'd0},   // R10
    {4'd1,  2'd0, 8'd0,   32'd0,    32'd64},  // R1
    {4'd10, 2'd0, 8'd160, 32'd0,    32'd0},   // R10 unmapped
    {4'd10, 2'd0, 8'd20,  32'd0,    32'd0},   // R10 alias reads zero
    {4'd2,  2'd0, 8'd8,   32'd0,    32'd0}    // R2
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input int req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 check(req, reg_rdata, exp);
  endtask

  task automatic irq_chk(input int req, input logic [3:0] exp);
    @(negedge clk);
    #1 check(req, {28'd0, cpu_irq}, {28'd0, exp});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    irq_chk(9, 4'b0000);            // R9
    rd(9, 8'd12, 32'd0);            // R9
    rd(9, 8'd40, 32'd0);            // R9

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][73:72])
        2'd1: wr(VEC[i][71:64], VEC[i][63:32]);
        2'd2: irq_chk(int'(VEC[i][77:74]), VEC[i][3:0]);
        default: rd(int'(VEC[i][77:74]), VEC[i][71:64], VEC[i][31:0]);
      endcase
    end

    // R3 external lines follow the level
    wr(8'd40, 32'hF);
    @(negedge clk); ext_irq = 4'h5;
    @(negedge clk);
    rd(3, 8'd8, 32'h5);             // R3
    irq_chk(8, 4'b1001);            // R8
    wr(8'd24, 32'h5);
    rd(3, 8'd8, 32'h5);             // R3 clear-only has no effect
    wr(8'd8, 32'h0);
    rd(3, 8'd8, 32'h5);             // R3 direct write has no effect
    rd(7, 8'd32, 32'h5);            // R7
    @(negedge clk); ext_irq = 4'h0;
    @(negedge clk);
    rd(3, 8'd8, 32'h0);             // R3
    irq_chk(8, 4'b1000);            // R8

    // R9 reset mid-run
    do_reset();
    irq_chk(9, 4'b0000);            // R9
    rd(9, 8'd12, 32'd0);            // R9
    rd(9, 8'd140, 32'd0);           // R9
    rd(9, 8'd40, 32'd0);            // R9

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule